// File: doc/BRIEF.md
# Periodic Interval Timer

This block raises a repeating interrupt at a programmable interval. A free-running divide-by-16 prescaler advances a 20-bit period counter. That counter climbs from zero to a programmed limit and then drops back to zero on its own. Each time it drops back, the block does two things. It sets an elapsed flag, and it advances a 12-bit tally of periods that software has not yet acknowledged. The interrupt line is the elapsed flag gated by an interrupt-enable bit.

Software reaches the block through a simple word-addressed read/write port. There are four words:

- **Control** (offset 0x00): writable.
- **Flag** (offset 0x04): read-only.
- **Acknowledge snapshot** (offset 0x08): read-only. Reading it returns the tally and the counter, and clears both the flag and the tally.
- **Peek snapshot** (offset 0x0C): read-only. It returns the same data with no side effect.

Clearing the run bit does not stop the counter at once. The counter finishes the period it is in, then parks at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, control reads 0x000FFFFF, and the flag word, both snapshots and `irq` read zero.
- R2: Control holds the interval limit in bits [19:0], the run bit in bit 24 and the interrupt-enable bit in bit 25. Every other control bit reads as zero. Writes to offsets 0x04, 0x08 and 0x0C change nothing.
- R3: With the run bit set and a limit of L, the counter returns to zero and the elapsed flag is set every (L+1)*16 clock cycles, counted from the write that sets the run bit while the block is idle.
- R4: The counter value (snapshot bits [19:0]) advances by one every 16 clock cycles while the block is running.
- R5: A read of offset 0x08 returns {tally[11:0], counter[19:0]} and clears the elapsed flag and the tally. If a wrap happens in the same cycle, the flag stays set and the tally becomes 1.
- R6: A read of offset 0x0C returns the same {tally, counter} layout and changes neither the flag nor the tally.
- R7: The tally (snapshot bits [31:20]) goes up by one on every wrap and holds at 4095.
- R8: `irq` is high exactly while the elapsed flag is set and the interrupt-enable bit is 1.
- R9: After the run bit is cleared, the counter completes its current period: it wraps, sets the flag and bumps the tally. It then stays at zero.
- R10: A read of offset 0x04 returns the elapsed flag in bit 0 and zeros elsewhere, and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Periodic interrupt request |

## Verification
The hardest state to reach is tally saturation. It needs 4096 unacknowledged wraps. The stimulus reaches it with a limit of zero, so each wrap costs 16 cycles and about 65,600 cycles are enough to pass 4095. One peek just before an acknowledge and one just after show that the tally holds, then clears.

The run-bit shutdown is also awkward. It is requested partway through a period. The bench then samples the counter mid-period, just after the final wrap, and again long after, to show that the block finished that one period and went quiet.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W  = 32;
    localparam int PIV_W   = 20;
    localparam int CNT_W   = 12;
    localparam int PRE_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int RUN_BIT = 24;
    localparam int IEN_BIT = 25;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_ACK   = 2'd2,
        SEL_PEEK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             irq_en;
        logic             run_en;
        logic [PIV_W-1:0] limit;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] tally;
        logic [PIV_W-1:0] count;
    } snap_t;

    localparam ctrl_t CTRL_RESET = '{irq_en: 1'b0, run_en: 1'b0, limit: {PIV_W{1'b1}}};

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.limit  = w[PIV_W-1:0];
        c.run_en = w[RUN_BIT];
        c.irq_en = w[IEN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[PIV_W-1:0]   = c.limit;
        w[RUN_BIT]     = c.run_en;
        w[IEN_BIT]     = c.irq_en;
        return w;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PRE_W = pit_pkg::PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick,
    output logic busy
);
    logic [PRE_W-1:0] pre_q;

    assign tick = &pre_q;
    assign busy = |pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (run || busy) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pit_core.sv
module pit_core #(
    parameter int PIV_W = pit_pkg::PIV_W,
    parameter int CNT_W = pit_pkg::CNT_W,
    parameter bit SAT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PIV_W-1:0] limit,
    input  logic             ack,
    output logic [PIV_W-1:0] count,
    output logic [CNT_W-1:0] tally,
    output logic             elapsed,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TALLY_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] tally_inc;
    logic [CNT_W-1:0] tally_nxt;

    generate
        if (SAT) begin : g_sat
            assign tally_inc = (tally == TALLY_MAX) ? TALLY_MAX : tally + 1'b1;
        end else begin : g_wrap
            assign tally_inc = tally + 1'b1;
        end
    endgenerate

    assign wrap      = tick && (count >= limit);
    assign tally_nxt = ack ? {{(CNT_W-1){1'b0}}, 1'b1} : tally_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            tally   <= '0;
            elapsed <= 1'b0;
        end else begin
            if (tick) begin
                count <= wrap ? '0 : count + 1'b1;
            end
            if (wrap) begin
                elapsed <= 1'b1;
                tally   <= tally_nxt;
            end else if (ack) begin
                elapsed <= 1'b0;
                tally   <= '0;
            end
        end
    end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  snap_t             snap,
    input  logic              elapsed,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              peek
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] rmux;

    assign sel  = reg_sel_e'(addr[3:2]);
    assign ack  = rd && (sel == SEL_ACK);
    assign peek = rd && (sel == SEL_PEEK);

    always_comb begin
        unique case (sel)
            SEL_CTRL: rmux = pack_ctrl(ctrl);
            SEL_FLAG: rmux = {{(DATA_W-1){1'b0}}, elapsed};
            SEL_ACK:  rmux = snap;
            SEL_PEEK: rmux = snap;
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            rdata <= '0;
        end else begin
            if (wr && (sel == SEL_CTRL)) begin
                ctrl <= unpack_ctrl(wdata);
            end
            if (rd) begin
                rdata <= rmux;
            end
        end
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    snap_t            snap;
    logic             tick;
    logic             pre_busy;
    logic             run;
    logic             ack;
    logic             peek;
    logic             wrap;
    logic             elapsed;
    logic [PIV_W-1:0] count;
    logic [CNT_W-1:0] tally;

    assign run  = ctrl.run_en || (count != '0);
    assign snap = '{tally: tally, count: count};
    assign irq  = elapsed && ctrl.irq_en;

    pit_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .busy (pre_busy)
    );

    pit_core #(.PIV_W(PIV_W), .CNT_W(CNT_W), .SAT(1'b1)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .limit   (ctrl.limit),
        .ack     (ack),
        .count   (count),
        .tally   (tally),
        .elapsed (elapsed),
        .wrap    (wrap)
    );

    pit_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .snap    (snap),
        .elapsed (elapsed),
        .ctrl    (ctrl),
        .rdata   (bus_rdata),
        .ack     (ack),
        .peek    (peek)
    );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
    parameter int PIV_W = pit_pkg::PIV_W,
    parameter int CNT_W = pit_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             irq_en,
    input logic             run_en,
    input logic             pre_busy,
    input logic             ack,
    input logic             peek,
    input logic             wrap,
    input logic             elapsed,
    input logic [PIV_W-1:0] count,
    input logic [CNT_W-1:0] tally
);
    localparam logic [CNT_W-1:0] TMAX = {CNT_W{1'b1}};

    // R4: the counter only steps up by one or returns to zero
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

    // R5: an acknowledge with no wrap leaves flag and tally clear
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !wrap) |=> (!elapsed && tally == '0));

    // R6: a peek never drops the flag
    a_r6_peek_keeps: assert property (@(posedge clk) disable iff (rst)
        (peek && elapsed) |=> elapsed);

    // R7: the tally holds at its ceiling unless acknowledged
    a_r7_tally_hold: assert property (@(posedge clk) disable iff (rst)
        (tally == TMAX && !ack) |=> (tally == TMAX));

    // R8: no interrupt while the enable bit is low
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R9: once stopped at zero with the run bit low, it stays there
    a_r9_parked: assert property (@(posedge clk) disable iff (rst)
        (!run_en && count == '0 && !pre_busy) |=> (count == '0 && !pre_busy));
endmodule

bind pit_timer pit_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .irq_en   (ctrl.irq_en),
    .run_en   (ctrl.run_en),
    .pre_busy (pre_busy),
    .ack      (ack),
    .peek     (peek),
    .wrap     (wrap),
    .elapsed  (elapsed),
    .count    (count),
    .tally    (tally)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int e0;
    int e2;
    logic        rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [3:0] A_CTRL = 4'h0, A_FLAG = 4'h4, A_ACK = 4'h8, A_PEEK = 4'hC;

    always #10 clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        rd_d <= bus_rd;
    end

    // monitor: pop expected read data the cycle after each read strobe
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string t);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic irq_chk(input logic e, input string t);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: run=hung expected=done");
            end
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                // R1 reset state
                irq_chk(1'b0, "R1");
                rd_chk(A_CTRL, 32'h000FFFFF, "R1");
                rd_chk(A_FLAG, 32'h0, "R1");
                rd_chk(A_ACK,  32'h0, "R1");
                rd_chk(A_PEEK, 32'h0, "R1");
                // R2 writes to read-only words ignored
                wr_reg(A_FLAG, 32'hFFFFFFFF);
                wr_reg(A_PEEK, 32'hFFFFFFFF);
                rd_chk(A_CTRL, 32'h000FFFFF, "R2");
                rd_chk(A_FLAG, 32'h0, "R2");
                // limit 3, run on, irq off: period 64
                wr_reg(A_CTRL, 32'h01000003);
                e0 = cyc;
                wait_until(e0 + 15); rd_chk(A_PEEK, 32'h0, "R4");
                rd_chk(A_PEEK, 32'h1, "R4");
                wait_until(e0 + 63); rd_chk(A_FLAG, 32'h0, "R3");
                rd_chk(A_FLAG, 32'h1, "R3");
                irq_chk(1'b0, "R8");
                rd_chk(A_PEEK, 32'h00100000, "R6");
                rd_chk(A_PEEK, 32'h00100000, "R6");
                rd_chk(A_FLAG, 32'h1, "R10");
                wait_until(e0 + 129); rd_chk(A_ACK, 32'h00200000, "R5");
                rd_chk(A_FLAG, 32'h0, "R5");
                rd_chk(A_PEEK, 32'h0, "R5");
                // R2 reserved bits read zero; irq enabled
                wr_reg(A_CTRL, 32'hF3F00003);
                rd_chk(A_CTRL, 32'h03000003, "R2");
                wait_until(e0 + 191); irq_chk(1'b0, "R8");
                @(negedge clk); irq_chk(1'b1, "R8");
                wait_until(e0 + 193); rd_chk(A_ACK, 32'h00100000, "R7");
                irq_chk(1'b0, "R8");
                // R9 stop mid-period
                wait_until(e0 + 199); wr_reg(A_CTRL, 32'h00000003);
                wait_until(e0 + 249); rd_chk(A_PEEK, 32'h00000003, "R9");
                wait_until(e0 + 299); rd_chk(A_PEEK, 32'h00100000, "R9");
                wait_until(e0 + 339); rd_chk(A_PEEK, 32'h00100000, "R9");
                rd_chk(A_FLAG, 32'h1, "R9");
                // R7 saturation with limit 0: period 16
                rd_chk(A_ACK, 32'h00100000, "R5");
                wr_reg(A_CTRL, 32'h01000000);
                e2 = cyc;
                wait_until(e2 + 1600); rd_chk(A_PEEK, 32'h06400000, "R7");
                wait_until(e2 + 65603); rd_chk(A_PEEK, 32'hFFF00000, "R7");
                rd_chk(A_ACK, 32'hFFF00000, "R7");
                rd_chk(A_PEEK, 32'h0, "R5");
                repeat (2) @(negedge clk);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule